// File: doc/BRIEF.md
# Edge-Triggered Interrupt Collector for a Serial Bus Controller

This block turns the level status flags of a serial peripheral controller into one interrupt line. Each flag has an edge detector, and a flag that goes from low to high latches a pending bit. A flag that stays high does not latch again, even after software clears the pending bit. A per-bit enable register selects which pending bits may drive the interrupt. The interrupt line is the OR of the pending bits that are enabled.

Software reaches the block through a small register port with three words. The first holds the live flag levels, read only. The second holds the pending bits, which are cleared by writing 1. The third holds the enable mask. A flag that is already high when its enable bit is set does not raise the interrupt. Before it waits, a driver therefore reads the live word and checks whether the condition already holds.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset the pending word (address 1) and the enable word (address 2) read 0, and `irq_o` is low.
- R2: A flag that was low on one clock edge and is high on the next sets its pending bit. The bit reads 1 from the cycle after that edge onward.
- R3: A flag that stays high sets its pending bit only once. After software clears the bit, it stays 0 for as long as the flag remains high.
- R4: A write to address 1 clears every pending bit that the written word has at 1. Bits written as 0 are left unchanged.
- R5: Writing all ones to address 1 clears every pending bit.
- R6: `irq_o` is high exactly when some pending bit has its enable bit set. A pending bit whose enable bit is 0 does not drive `irq_o`.
- R7: Edges latch while the enable bit is 0. Setting the enable bit for an already pending cause raises `irq_o` in the cycle after the write.
- R8: If a rising edge and a clear of the same bit fall in the same cycle, the bit stays set.
- R9: Address 0 returns the current flag levels, independent of the pending and enable words. Address 3 reads 0, as does every bit above the flag count. Writes to addresses 0 and 3 have no effect.
- R10: Flag and bit positions are: 0 transfer done, 1 transfer ready, 2 read queue ready, 3 write queue ready, 4 read queue empty, 5 read queue full, 6 write queue empty, 7 write queue full, and 8 to 11 the overflow and underflow flags. Bit i of each word belongs to flag i.
- R11: If a flag is already high and has no pending bit, setting its enable bit does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flags_i | input | NUM_FLAGS | Live status flag levels |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Word select: 0 live, 1 pending, 2 enable |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the defaults, twelve flags and a 32-bit data word. This puts every named flag position within reach, including the four overflow and underflow bits, as well as the upper data bits that must read zero. Walking a single flag across all twelve positions checks the bit mapping, and the same clear-write and edge on one bit in the same cycle checks the collision rule. Holding a flag high across a clear and a mask change checks the cases where no interrupt may appear.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        WORD_LIVE    = 2'd0,
        WORD_PENDING = 2'd1,
        WORD_ENABLE  = 2'd2,
        WORD_SPARE   = 2'd3
    } word_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level_i;
        rise_o    = level_i & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    typedef struct packed {
        logic [N-1:0] pend;
    } bank_state_t;

    bank_state_t st_d, st_q;

    // Set has priority over clear on the same bit
    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr_i) | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;

    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((pend_o & $past(rise_i)) == $past(rise_i)));

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i == '0) |=> ((pend_o & ~$past(pend_o)) == '0));

    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~rise_i) != '0) |=> ((pend_o & $past(clr_i & ~rise_i)) == '0));

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & rise_i) != '0) |=> ((pend_o & $past(clr_i & rise_i)) == $past(clr_i & rise_i)));
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
    import irq_edge_pkg::*;
#(
    parameter int NUM_FLAGS = 12,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] flags_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o
);
    localparam int PAD_W = DATA_W - NUM_FLAGS;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] enable;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [NUM_FLAGS-1:0] rise;
    logic [NUM_FLAGS-1:0] clr;
    logic [NUM_FLAGS-1:0] pend;
    logic [NUM_FLAGS-1:0] wdata_n;
    logic [NUM_FLAGS-1:0] rdata_n;
    logic                 wr_en;
    word_sel_e            sel;

    assign sel     = word_sel_e'(bus_addr_i);
    assign wr_en   = bus_sel_i & bus_wr_i;
    assign wdata_n = bus_wdata_i[NUM_FLAGS-1:0];

    irq_edge_detect #(.N(NUM_FLAGS)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (flags_i),
        .rise_o  (rise)
    );

    irq_cause_bank #(.N(NUM_FLAGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (rise),
        .clr_i  (clr),
        .pend_o (pend)
    );

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (wr_en && sel == WORD_ENABLE)  st_d.enable = wdata_n;
        if (wr_en && sel == WORD_PENDING) clr         = wdata_n;
        unique case (sel)
            WORD_LIVE:    rdata_n = flags_i;
            WORD_PENDING: rdata_n = pend;
            WORD_ENABLE:  rdata_n = st_q.enable;
            default:      rdata_n = '0;
        endcase
        irq_o = |(pend & st_q.enable);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (PAD_W > 0) begin : g_pad
            logic unused_hi;
            assign unused_hi   = ^bus_wdata_i[DATA_W-1:NUM_FLAGS];
            assign bus_rdata_o = {{PAD_W{1'b0}}, rdata_n};
        end else begin : g_nopad
            assign bus_rdata_o = rdata_n;
        end
    endgenerate

    assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.enable == '0) |-> !irq_o);

    assert_late_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == WORD_ENABLE && (pend & wdata_n) != '0 && clr == '0) |=> irq_o);
endmodule

// File: tb/sim_irq_edge_ctrl.sv
module sim_irq_edge_ctrl;
    localparam int NF = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] flags = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_edge_ctrl #(.NUM_FLAGS(NF), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .flags_i(flags),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic set_flags(input logic [NF-1:0] f);
        @(negedge clk);
        flags = f;
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [DW-1:0] d;
        bus_read(2'd1, d); check("R1 pending", d, 0);
        bus_read(2'd2, d); check("R1 enable", d, 0);
        check("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_edge_and_enable;
        logic [DW-1:0] d;
        set_flags(12'h001);
        bus_read(2'd1, d); check("R2 done edge", d, 32'h1);
        check("R7 masked no irq", {31'd0, irq}, 0);
        bus_write(2'd2, 32'h1);
        check("R7 late enable irq", {31'd0, irq}, 1);
    endtask

    task automatic t_clear_held;
        logic [DW-1:0] d;
        bus_write(2'd1, 32'h0);
        bus_read(2'd1, d); check("R4 zero write keeps", d, 32'h1);
        bus_write(2'd1, 32'h1);
        bus_read(2'd1, d); check("R4 cleared", d, 32'h0);
        check("R6 irq drops", {31'd0, irq}, 0);
        repeat (5) @(negedge clk);
        bus_read(2'd1, d); check("R3 held flag no relatch", d, 32'h0);
        set_flags(12'h000);
        bus_write(2'd2, 32'h0);
    endtask

    task automatic t_unmask_high;
        logic [DW-1:0] d;
        set_flags(12'h008);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_write(2'd2, 32'h8);
        check("R11 no irq on unmask", {31'd0, irq}, 0);
        bus_read(2'd0, d); check("R9 live level", d, 32'h8);
        bus_write(2'd0, 32'hFFF);
        bus_write(2'd3, 32'hFFF);
        bus_read(2'd3, d); check("R9 spare reads 0", d, 32'h0);
        bus_read(2'd2, d); check("R9 enable unchanged", d, 32'h8);
        bus_read(2'd1, d); check("R9 pending unchanged", d, 32'h0);
        set_flags(12'h000);
        bus_write(2'd2, 32'h0);
    endtask

    task automatic t_multi_clear_all;
        logic [DW-1:0] d;
        set_flags(12'hF00);
        bus_read(2'd1, d); check("R10 error bits 8-11", d, 32'hF00);
        bus_write(2'd2, 32'h004);
        check("R6 unselected no irq", {31'd0, irq}, 0);
        bus_write(2'd2, 32'h100);
        check("R6 selected irq", {31'd0, irq}, 1);
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, d); check("R5 all cleared", d, 32'h0);
        check("R5 irq low", {31'd0, irq}, 0);
        set_flags(12'h000);
        bus_write(2'd2, 32'h0);
    endtask

    task automatic t_collision;
        logic [DW-1:0] d;
        set_flags(12'h020);
        set_flags(12'h000);
        @(negedge clk);
        flags = 12'h020;
        sel = 1'b1; wr = 1'b1; addr = 2'd1; wdata = 32'h20;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
        bus_read(2'd1, d); check("R8 set wins", d, 32'h20);
        bus_write(2'd1, 32'h20);
        set_flags(12'h000);
    endtask

    task automatic t_positions;
        logic [DW-1:0] d;
        for (int i = 0; i < NF; i++) begin
            set_flags(NF'(1) << i);
            bus_read(2'd1, d); check("R10 position", d, 32'(1) << i);
            bus_write(2'd1, 32'hFFFF_FFFF);
            set_flags('0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_edge_and_enable();
        t_clear_held();
        t_unmask_high();
        t_multi_clear_all();
        t_collision();
        t_positions();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule